// File: doc/BRIEF.md
# Bit-Masked Crypto Control Register Bank

This block holds the control and status registers that sit in front of a crypto accelerator's engines. A single-cycle register port carries reads and writes. On the three masked control registers, each write is qualified per bit: the upper 16 bits of the write word act as the enable for the matching bit of the lower 16. Software can therefore set or clear one field without first reading the register back.

The bank drives soft-reset lines into the public-key unit and the symmetric/hash unit. A reset request bit asserts its line for a fixed number of cycles and then clears itself, so software can poll until the register reads zero. The bank also drives the hash engine's mode, padding and enable fields and the byte-swap selects of the data FIFOs.

A plain interrupt-enable register and a sticky write-one-to-clear interrupt status register feed one interrupt line. A separate sticky flag records that a hash result is ready. Each event source raises its status through a one-bit done input.

Top module: `crypto_ctrl_regs`

## Requirements
- R1: On a write to a masked register (word address 0, 1 or 2), bit i of the low half takes bit i of the write data only when bit i+16 of the write data is 1. Every other bit keeps its value.
- R2: In the hash-control register (address 1), bit 0 is `hash_en`, bit 1 is `hash_pad_en` and bits 7:4 are `hash_mode`. In the FIFO-control register (address 2), bit 0 is `fifo_in_swap` and bit 1 is `fifo_out_swap`. Writing 0xFFFF0000 to address 1 clears all hash controls.
- R3: In the reset-control register (address 0), bit 0 requests a reset of the public-key unit (`pk_rst`) and bit 1 requests a reset of the symmetric/hash unit (`sym_rst`). A masked write of 1 to a bit holds its reset output for exactly RST_CYCLES (4) cycles, and the bit then returns to 0 by itself. While the reset is held, the bit reads as 1. A request that arrives while the reset is already held does not lengthen it. A data 1 with a mask of 0 starts nothing.
- R4: The interrupt-enable register (address 3) is a plain 32-bit register with no mask, written in full and read back in full. `irq` is high when a status bit is set and its enable bit (same position) is set. With the enable register at zero, `irq` stays low.
- R5: The interrupt status register (address 4) is sticky. A high on `evt_done[i]` sets bit i. Writing a 1 to bit i clears it. When a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R6: `hash_done` sets the hash-valid flag (bit 0 of address 5, output `hash_valid`). Writing 1 to that bit clears the flag and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R7: Reads of masked registers return zero in bits 31:16. Reads of unmapped addresses (6, 7) return zero, and writes to them change nothing. `reg_rdata` is zero when no read is presented.
- R8: After reset, every register reads zero and every control output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (3) | Word address |
| reg_wdata | input | 32 | Write data; upper half is the bit mask on masked registers |
| reg_ready | output | 1 | Access accepted in the same cycle |
| reg_rdata | output | 32 | Read data, combinational during a read |
| evt_done | input | NUM_EVT (8) | Per-source done events into the status register |
| hash_done | input | 1 | Hash result ready event |
| pk_rst | output | 1 | Soft reset to the public-key unit |
| sym_rst | output | 1 | Soft reset to the symmetric/hash unit |
| hash_en | output | 1 | Hash engine enable |
| hash_pad_en | output | 1 | Hardware padding enable |
| hash_mode | output | 4 | Hash algorithm select |
| fifo_in_swap | output | 1 | Input FIFO byte-swap select |
| fifo_out_swap | output | 1 | Output FIFO byte-swap select |
| irq | output | 1 | Interrupt request |
| hash_valid | output | 1 | Hash-valid flag |

## Verification
The assertions assume that `reg_valid` and the other inputs are stable around the clock edge. They also assume that a read is never held across a cycle in which an event could change the value being read, because the read-back checks compare same-cycle data. The bench drives every input just after the falling edge, keeps each access to exactly one rising edge, and samples outputs on the next falling edge. Event pulses last one edge and are aligned with the write they race against, so the set-versus-clear cases land in a single cycle.

// File: rtl/cregs_pkg.sv
package cregs_pkg;
  localparam int unsigned A_RSTC = 0;
  localparam int unsigned A_HCTL = 1;
  localparam int unsigned A_FCTL = 2;
  localparam int unsigned A_IEN  = 3;
  localparam int unsigned A_ISTS = 4;
  localparam int unsigned A_HVAL = 5;

  localparam int unsigned HALF_W = 16;

  // merge of a masked write: mask in the upper half picks which low bits change
  function automatic logic [HALF_W-1:0] masked_merge(input logic [HALF_W-1:0] old_v,
                                                     input logic [31:0] wd);
    logic [HALF_W-1:0] m;
    m = wd[31:HALF_W];
    return (old_v & ~m) | (wd[HALF_W-1:0] & m);
  endfunction

  // sticky status update, set has priority over clear
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/cregs_mreg.sv
module cregs_mreg
  import cregs_pkg::*;
#(
  parameter logic [HALF_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (we) q <= masked_merge(q, wdata);
  end
endmodule

// File: rtl/cregs_sticky.sv
module cregs_sticky
  import cregs_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [31:0] nxt;
  assign nxt = sticky_next(32'(q), 32'(clr), 32'(set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end
endmodule

// File: rtl/cregs_rstseq.sv
module cregs_rstseq #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (cnt != '0)                 cnt <= cnt - 1'b1;
    else if (start)                     cnt <= LOAD;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/crypto_ctrl_regs.sv
module crypto_ctrl_regs
  import cregs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned NUM_EVT    = 8,
  parameter int unsigned RST_CYCLES = 4,
  parameter int unsigned MODE_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               reg_ready,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_done,
  input  logic               hash_done,
  output logic               pk_rst,
  output logic               sym_rst,
  output logic               hash_en,
  output logic               hash_pad_en,
  output logic [MODE_W-1:0]  hash_mode,
  output logic               fifo_in_swap,
  output logic               fifo_out_swap,
  output logic               irq,
  output logic               hash_valid
);
  localparam int unsigned NUM_RST = 2;
  localparam int unsigned MODE_LSB = 4;

  // named access strobes
  logic wr_any, rd_any;
  logic wr_rstc, wr_hctl, wr_fctl, wr_ien, wr_ists, wr_hval;

  assign wr_any  = reg_valid && reg_write;
  assign rd_any  = reg_valid && !reg_write;
  assign wr_rstc = wr_any && (reg_addr == ADDR_W'(A_RSTC));
  assign wr_hctl = wr_any && (reg_addr == ADDR_W'(A_HCTL));
  assign wr_fctl = wr_any && (reg_addr == ADDR_W'(A_FCTL));
  assign wr_ien  = wr_any && (reg_addr == ADDR_W'(A_IEN));
  assign wr_ists = wr_any && (reg_addr == ADDR_W'(A_ISTS));
  assign wr_hval = wr_any && (reg_addr == ADDR_W'(A_HVAL));

  assign reg_ready = reg_valid;

  // masked control registers
  logic [HALF_W-1:0] hctl_q, fctl_q;

  cregs_mreg u_hctl (.clk(clk), .rst_n(rst_n), .we(wr_hctl), .wdata(reg_wdata), .q(hctl_q));
  cregs_mreg u_fctl (.clk(clk), .rst_n(rst_n), .we(wr_fctl), .wdata(reg_wdata), .q(fctl_q));

  assign hash_en       = hctl_q[0];
  assign hash_pad_en   = hctl_q[1];
  assign hash_mode     = hctl_q[MODE_LSB +: MODE_W];
  assign fifo_in_swap  = fctl_q[0];
  assign fifo_out_swap = fctl_q[1];

  // self-clearing reset requests
  logic [NUM_RST-1:0] rst_start, rst_busy;

  for (genvar g = 0; g < NUM_RST; g++) begin : g_rst
    assign rst_start[g] = wr_rstc && reg_wdata[HALF_W + g] && reg_wdata[g];
    cregs_rstseq #(.CYCLES(RST_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(rst_start[g]), .busy(rst_busy[g]));
  end

  assign pk_rst  = rst_busy[0];
  assign sym_rst = rst_busy[1];

  // plain interrupt enable
  logic [31:0] ien_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= reg_wdata;
  end

  // sticky status and hash-valid flag
  logic [NUM_EVT-1:0] ists_q, ists_clr;
  logic [0:0]         hval_q, hval_clr;

  assign ists_clr = wr_ists ? reg_wdata[NUM_EVT-1:0] : '0;
  assign hval_clr = wr_hval ? reg_wdata[0:0] : 1'b0;

  cregs_sticky #(.W(NUM_EVT)) u_ists (
    .clk(clk), .rst_n(rst_n), .set(evt_done), .clr(ists_clr), .q(ists_q));
  cregs_sticky #(.W(1)) u_hval (
    .clk(clk), .rst_n(rst_n), .set(hash_done), .clr(hval_clr), .q(hval_q));

  assign hash_valid = hval_q[0];
  assign irq        = |(ists_q & ien_q[NUM_EVT-1:0]);

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (rd_any) begin
      case (reg_addr)
        ADDR_W'(A_RSTC): reg_rdata = {{(32-NUM_RST){1'b0}}, rst_busy};
        ADDR_W'(A_HCTL): reg_rdata = {16'h0, hctl_q};
        ADDR_W'(A_FCTL): reg_rdata = {16'h0, fctl_q};
        ADDR_W'(A_IEN):  reg_rdata = ien_q;
        ADDR_W'(A_ISTS): reg_rdata = {{(32-NUM_EVT){1'b0}}, ists_q};
        ADDR_W'(A_HVAL): reg_rdata = {31'h0, hval_q};
        default:         reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/crypto_ctrl_regs_chk.sv
module crypto_ctrl_regs_chk
  import cregs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned NUM_EVT    = 8,
  parameter int unsigned RST_CYCLES = 4,
  parameter int unsigned MODE_W     = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_valid,
  input logic               reg_write,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_EVT-1:0] evt_done,
  input logic               hash_done,
  input logic               pk_rst,
  input logic               sym_rst,
  input logic               hash_en,
  input logic [MODE_W-1:0]  hash_mode,
  input logic               irq,
  input logic               hash_valid,
  input logic [15:0]        hctl_q,
  input logic [NUM_EVT-1:0] ists_q,
  input logic [31:0]        ien_q
);
  logic [7:0] pk_run, sym_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_run  <= '0;
      sym_run <= '0;
    end else begin
      pk_run  <= pk_rst  ? ((pk_run  == 8'hFF) ? pk_run  : pk_run  + 1'b1) : 8'h0;
      sym_run <= sym_rst ? ((sym_run == 8'hFF) ? sym_run : sym_run + 1'b1) : 8'h0;
    end
  end

  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == ADDR_W'(A_HCTL) && reg_wdata[31:16] == 16'h0)
    |=> $stable(hctl_q));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == ADDR_W'(A_HCTL) && reg_wdata == 32'hFFFF_0000)
    |=> (!hash_en && hash_mode == '0));

  p_pk_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pk_rst) |-> (pk_run == 8'(RST_CYCLES)));

  p_sym_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sym_rst) |-> (sym_run == 8'(RST_CYCLES)));

  p_rst_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_addr == ADDR_W'(A_RSTC))
    |-> (reg_rdata[1:0] == {sym_rst, pk_rst}));

  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 32'h0) |-> !irq);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done != '0) |=> ((ists_q & $past(evt_done)) == $past(evt_done)));

  p_hv_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hash_done |=> hash_valid);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_addr <= ADDR_W'(A_FCTL)) |-> (reg_rdata[31:16] == 16'h0));

  p_idle_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |-> (reg_rdata == 32'h0));
endmodule

bind crypto_ctrl_regs crypto_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .RST_CYCLES(RST_CYCLES), .MODE_W(MODE_W)
) u_chk (.*);

// File: tb/crypto_ctrl_regs_test.sv
`timescale 1ns/1ps
module crypto_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_done = '0;
  logic        hash_done = 1'b0;
  logic        pk_rst, sym_rst, hash_en, hash_pad_en;
  logic [3:0]  hash_mode;
  logic        fifo_in_swap, fifo_out_swap, irq, hash_valid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  crypto_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
    .reg_rdata(reg_rdata), .evt_done(evt_done), .hash_done(hash_done),
    .pk_rst(pk_rst), .sym_rst(sym_rst), .hash_en(hash_en),
    .hash_pad_en(hash_pad_en), .hash_mode(hash_mode),
    .fifo_in_swap(fifo_in_swap), .fifo_out_swap(fifo_out_swap),
    .irq(irq), .hash_valid(hash_valid));

  // {addr, write data, expected read-back}
  localparam int NV = 12;
  localparam logic [66:0] VEC [NV] = '{
    {3'd1, 32'hFFFF_00F3, 32'h0000_00F3},   // R1 full mask
    {3'd1, 32'h0001_0000, 32'h0000_00F2},   // R1 clear one bit
    {3'd1, 32'h00F0_0050, 32'h0000_0052},   // R2 mode field only
    {3'd1, 32'h0000_FFFF, 32'h0000_0052},   // R1 no mask, no change
    {3'd1, 32'hFFFF_0000, 32'h0000_0000},   // R2 idle
    {3'd2, 32'h0003_0003, 32'h0000_0003},   // R2 both swaps
    {3'd2, 32'h0002_0000, 32'h0000_0001},   // R1 clear out swap
    {3'd2, 32'h8000_8000, 32'h0000_8001},   // R1 top bit
    {3'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R4 plain
    {3'd3, 32'h0000_0000, 32'h0000_0000},   // R4 disable all
    {3'd6, 32'hFFFF_FFFF, 32'h0000_0000},   // R7 unmapped
    {3'd2, 32'hFFFF_1234, 32'h0000_1234}    // R7 upper half zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start just after a falling edge and return at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R8 reg reset", d, 32'h0);
    end
    check("R8 outputs reset",
          {22'h0, pk_rst, sym_rst, hash_en, hash_pad_en, hash_mode, fifo_in_swap,
           fifo_out_swap, irq, hash_valid}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      if (i == 0) check("R2 hash fields", {27'h0, hash_mode, hash_pad_en, hash_en}, 32'h3F);
      if (i == 7) check("R2 fifo fields", {30'h0, fifo_out_swap, fifo_in_swap}, 32'h1);
      rd(VEC[i][66:64], d);
      check("R1/R2/R4/R7 table", d, VEC[i][31:0]);
    end

    // R3 data without mask starts nothing
    wr(3'd0, 32'h0000_0003);
    check("R3 no mask no reset", {30'h0, sym_rst, pk_rst}, 32'h0);

    // R3 length of pk reset
    wr(3'd0, 32'h0001_0001);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      if (pk_rst) hi++;
      idle();
    end
    check("R3 pk reset length", 32'(hi), 32'd4);
    rd(3'd0, d);
    check("R3 self clear", d, 32'h0);

    // R3 sym reset reads 1 while held
    wr(3'd0, 32'h0002_0002);
    rd(3'd0, d);
    check("R3 busy read", d, 32'h2);
    repeat (5) idle();

    // R3 no extension on second request
    wr(3'd0, 32'h0001_0001);
    wr(3'd0, 32'h0001_0001);
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      if (pk_rst) hi++;
      idle();
    end
    check("R3 no extension", 32'(hi), 32'd3);

    // R5 sticky status
    evt_done = 8'h05;
    idle();
    evt_done = 8'h00;
    idle();
    rd(3'd4, d);
    check("R5 sticky set", d, 32'h05);
    wr(3'd4, 32'h0000_0001);
    rd(3'd4, d);
    check("R5 w1c", d, 32'h04);
    wr(3'd4, 32'h0000_0004);
    evt_done = 8'h04;
    wr(3'd4, 32'h0000_0004);
    evt_done = 8'h00;
    rd(3'd4, d);
    check("R5 set wins", d, 32'h04);

    // R4 interrupt gating
    check("R4 irq off when disabled", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0000_0004);
    check("R4 irq on", {31'h0, irq}, 32'h1);
    wr(3'd4, 32'h0000_0004);
    check("R4 irq after clear", {31'h0, irq}, 32'h0);

    // R6 hash valid flag
    hash_done = 1'b1;
    idle();
    hash_done = 1'b0;
    check("R6 set", {31'h0, hash_valid}, 32'h1);
    wr(3'd5, 32'h0000_0000);
    rd(3'd5, d);
    check("R6 write 0 keeps", d, 32'h1);
    wr(3'd5, 32'h0000_0001);
    check("R6 clear", {31'h0, hash_valid}, 32'h0);
    hash_done = 1'b1;
    wr(3'd5, 32'h0000_0001);
    hash_done = 1'b0;
    check("R6 set wins", {31'h0, hash_valid}, 32'h1);

    // R7 unmapped read and idle data
    rd(3'd7, d);
    check("R7 unmapped read", d, 32'h0);
    #1 check("R7 idle rdata", reg_rdata, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule